// File: doc/BRIEF.md
# Ternary First-Order Noise-Shaping Modulator

This block turns a stream of signed multibit samples into a stream of ternary symbols (+1, 0, −1), one symbol per accepted sample. It works as a first-order loop. On every accepted sample, a running accumulator takes in the new input and gives back the previously emitted symbol, scaled to half the input span. The updated accumulator then goes to a three-level slicer whose two decision points sit at plus and minus one quarter of the input span. Over time the quantization error is pushed toward high frequencies, so a moving average of the symbols follows the input.

The input span λ is set by the sample width: λ/2 = 2^(DATA_W−1). The block is placed wherever a multibit signal has to enter a short-word ternary processing chain. Samples arrive with a qualifying strobe. On cycles without the strobe, the loop state is frozen.

Top module: `tsdm_ternary_mod`

## Requirements
- R1: While the synchronous reset is high, the accumulator is cleared and the output reads code 00 (zero). After reset the loop behaves as if no sample had ever been taken.
- R2: When the updated accumulator is greater than or equal to +λ/4, the emitted symbol is +1, encoded as 01. The boundary value itself yields +1.
- R3: When the updated accumulator is less than or equal to −λ/4, the emitted symbol is −1, encoded as 11. The boundary value itself yields −1.
- R4: When the updated accumulator lies strictly between −λ/4 and +λ/4, the emitted symbol is 0, encoded as 00.
- R5: The accumulator update is v(k) = v(k−1) + x(k) − (λ/2)·y(k−1). Here y(k−1) is the symbol emitted for the previous accepted sample.
- R6: On a cycle where in_valid is low, neither the accumulator nor the output changes, whatever the sample value.
- R7: The code 10 never appears on the output.
- R8: For any sequence of in-range inputs, |Σx − (λ/2)·Σy| taken since reset stays at or below 3λ/4. Equivalently, the accumulator never leaves ±3λ/4, which fits within DATA_W+2 bits without overflow.
- R9: The output is registered. The symbol for a sample accepted at a clock edge appears just after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_sample for this cycle |
| in_sample | input | DATA_W | Signed two's-complement input sample |
| trit_out | output | 2 | Ternary symbol: 01 = +1, 00 = 0, 11 = −1 |

## Verification
The accumulator-bound and slicer properties are only meaningful if every sample is a legal two's-complement value of DATA_W bits. The full negative code −λ/2 is allowed, so that limit is exercised as well. The stimulus drives only such values: every DC level in the range in turn, followed by a long pseudo-random walk with random gaps in the strobe. The properties also rely on the reset being applied before the first valid sample. The bench holds reset for several cycles at the start and again before each DC level.

// File: rtl/tsdm_pkg.sv
package tsdm_pkg;

   // Two-bit two's-complement ternary symbol; 2'b10 is illegal.
   typedef enum logic [1:0] {
      TRIT_ZERO = 2'b00,
      TRIT_POS  = 2'b01,
      TRIT_NEG  = 2'b11
   } trit_e;

   // Number of guard bits the accumulator needs beyond the sample width.
   localparam int unsigned TSDM_MIN_GUARD = 2;

endpackage

// File: rtl/tsdm_feedback.sv
// Maps the previously emitted symbol to its loop weight of +/- half span.
module tsdm_feedback
   import tsdm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2
) (
   input  trit_e                    sym,
   output logic signed [ACC_W-1:0]  fb_val
);

   localparam logic signed [ACC_W-1:0] HALF_POS = ACC_W'(1) <<< (DATA_W - 1);
   localparam logic signed [ACC_W-1:0] HALF_NEG = -HALF_POS;

   always_comb begin
      unique case (sym)
         TRIT_POS: fb_val = HALF_POS;
         TRIT_NEG: fb_val = HALF_NEG;
         default:  fb_val = '0;
      endcase
   end

endmodule

// File: rtl/tsdm_integrator.sv
// Combinational next-state for the loop accumulator: acc + x - fb.
module tsdm_integrator #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2
) (
   input  logic signed [ACC_W-1:0]  acc_cur,
   input  logic signed [DATA_W-1:0] sample,
   input  logic signed [ACC_W-1:0]  fb_val,
   output logic signed [ACC_W-1:0]  acc_nxt
);

   localparam int unsigned EXT_W = ACC_W - DATA_W;

   logic signed [ACC_W-1:0] sample_ext;

   // Sign extension of the input to accumulator width.
   generate
      if (EXT_W == 0) begin : g_no_ext
         assign sample_ext = sample;
      end else begin : g_ext
         assign sample_ext = {{EXT_W{sample[DATA_W-1]}}, sample};
      end
   endgenerate

   assign acc_nxt = acc_cur + sample_ext - fb_val;

endmodule

// File: rtl/tsdm_quantizer.sv
// Three-level slicer with decision points at +/- one quarter of the span.
module tsdm_quantizer
   import tsdm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2
) (
   input  logic signed [ACC_W-1:0] level,
   output trit_e                   sym
);

   localparam logic signed [ACC_W-1:0] QTR_POS = ACC_W'(1) <<< (DATA_W - 2);
   localparam logic signed [ACC_W-1:0] QTR_NEG = -QTR_POS;

   logic at_or_above;
   logic at_or_below;

   assign at_or_above = (level >= QTR_POS);
   assign at_or_below = (level <= QTR_NEG);

   always_comb begin
      if (at_or_above)
         sym = TRIT_POS;
      else if (at_or_below)
         sym = TRIT_NEG;
      else
         sym = TRIT_ZERO;
   end

endmodule

// File: rtl/tsdm_ternary_mod.sv
// First-order ternary noise-shaping modulator, top level.
module tsdm_ternary_mod
   import tsdm_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ACC_GUARD = TSDM_MIN_GUARD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   output logic [1:0]        trit_out
);

   localparam int unsigned ACC_W = DATA_W + ACC_GUARD;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("tsdm_ternary_mod: DATA_W must be at least 2");
      end
      if (ACC_GUARD < TSDM_MIN_GUARD) begin : g_bad_guard
         $error("tsdm_ternary_mod: ACC_GUARD below minimum of two");
      end
   endgenerate

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_d;
   logic signed [ACC_W-1:0] fb_val;
   trit_e                   sym_q;
   trit_e                   sym_d;

   tsdm_feedback #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_fb (
      .sym    (sym_q),
      .fb_val (fb_val)
   );

   tsdm_integrator #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_int (
      .acc_cur (acc_q),
      .sample  ($signed(in_sample)),
      .fb_val  (fb_val),
      .acc_nxt (acc_d)
   );

   tsdm_quantizer #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_q (
      .level (acc_d),
      .sym   (sym_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         sym_q <= TRIT_ZERO;
      end else if (in_valid) begin
         acc_q <= acc_d;
         sym_q <= sym_d;
      end
   end

   assign trit_out = sym_q;

endmodule

// File: rtl/tsdm_ternary_mod_chk.sv
module tsdm_ternary_mod_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic [1:0]              trit_out,
   input logic signed [ACC_W-1:0] acc_q
);

   localparam int QTR = 1 << (DATA_W - 2);
   localparam int LIM = 3 * QTR;

   int acc_i;
   assign acc_i = int'(acc_q);

   // R7: the illegal code never leaves the block
   a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
      trit_out != 2'b10);

   // R6: an idle cycle freezes the output
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(trit_out) && $stable(acc_q));

   // R8: accumulator stays within +/- 3/4 of the span
   a_r8_acc_bound: assert property (@(posedge clk) disable iff (rst)
      (acc_i <= LIM) && (acc_i >= -LIM));

   // R2: a +1 symbol pairs with an accumulator at or above +quarter span
   a_r2_pos_slice: assert property (@(posedge clk) disable iff (rst)
      trit_out == 2'b01 |-> acc_i >= QTR);

   // R3: a -1 symbol pairs with an accumulator at or below -quarter span
   a_r3_neg_slice: assert property (@(posedge clk) disable iff (rst)
      trit_out == 2'b11 |-> acc_i <= -QTR);

   // R4: a zero symbol pairs with an accumulator strictly inside the band
   a_r4_zero_slice: assert property (@(posedge clk) disable iff (rst)
      trit_out == 2'b00 |-> (acc_i < QTR) && (acc_i > -QTR));

endmodule

bind tsdm_ternary_mod tsdm_ternary_mod_chk #(
   .DATA_W (DATA_W),
   .ACC_W  (ACC_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .trit_out (trit_out),
   .acc_q    (acc_q)
);

// File: tb/tsdm_ternary_mod_tb.sv
module tsdm_ternary_mod_tb;

   localparam int W    = 8;
   localparam int HALF = 1 << (W - 1);
   localparam int QTR  = 1 << (W - 2);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_sample = '0;
   logic [1:0]   trit_out;

   int n_chk  = 0;
   int n_fail = 0;
   int mv = 0;   // model accumulator
   int my = 0;   // model symbol
   int sx = 0;   // sum of accepted inputs since reset
   int sy = 0;   // sum of emitted symbols since reset

   always #4 clk = ~clk;   // 125 MHz

   tsdm_ternary_mod #(.DATA_W(W)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .trit_out  (trit_out)
   );

   function automatic int decode(logic [1:0] c);
      case (c)
         2'b01:   return 1;
         2'b00:   return 0;
         2'b11:   return -1;
         default: return 99;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      mv = 0; my = 0; sx = 0; sy = 0;
      // R1: output reads zero straight out of reset
      chk(trit_out == 2'b00, "R1", decode(trit_out), 0);
   endtask

   // Drive one cycle, advance the model, compare after the edge.
   task automatic step(int x, bit v);
      int act;
      in_sample = W'(x);
      in_valid  = v;
      @(posedge clk);
      #1;
      if (v) begin
         mv = mv + x - HALF * my;   // R5: feedback subtracts half span
         my = (mv >= QTR) ? 1 : ((mv <= -QTR) ? -1 : 0);
         sx += x;
         sy += my;
      end
      act = decode(trit_out);
      chk(trit_out != 2'b10, "R7", act, my);
      if (my == 1)
         chk(act == my, "R2", act, my);
      else if (my == -1)
         chk(act == my, "R3", act, my);
      else
         chk(act == my, "R4", act, my);
      // R8: cumulative error bounded by 3/4 span
      chk((sx - HALF * sy <= 3 * QTR) && (sx - HALF * sy >= -3 * QTR),
          "R8", sx - HALF * sy, 3 * QTR);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();

      // Boundary of the positive decision point (R2 / R4)
      step(QTR, 1'b1);
      chk(decode(trit_out) == 1, "R2", decode(trit_out), 1);
      // R5: with y=+1 stored, x=0 gives v=QTR-HALF=-QTR, so -1
      step(0, 1'b1);
      chk(decode(trit_out) == -1, "R5", decode(trit_out), -1);

      do_reset();
      step(QTR - 1, 1'b1);
      chk(decode(trit_out) == 0, "R4", decode(trit_out), 0);

      do_reset();
      step(-QTR, 1'b1);
      chk(decode(trit_out) == -1, "R3", decode(trit_out), -1);

      do_reset();
      step(-QTR + 1, 1'b1);
      chk(decode(trit_out) == 0, "R4", decode(trit_out), 0);

      // R9: output unchanged until the edge that takes the sample
      do_reset();
      in_sample = W'(100);
      in_valid  = 1'b1;
      #2;
      chk(trit_out == 2'b00, "R9", decode(trit_out), 0);
      @(posedge clk);
      #1;
      mv = 100; my = 1; sx = 100; sy = 1;
      chk(decode(trit_out) == 1, "R9", decode(trit_out), 1);

      // R6: idle cycles with extreme samples leave state untouched
      for (int i = 0; i < 6; i++) begin
         step((i % 2) ? -HALF : HALF - 1, 1'b0);
         chk(decode(trit_out) == 1, "R6", decode(trit_out), 1);
      end
      // Resume: continuing from preserved state (v=100,y=+1) with x=0 -> -28 -> 0
      step(0, 1'b0);
      step(0, 1'b1);
      chk(decode(trit_out) == 0, "R6", decode(trit_out), 0);

      // R1: reset in the middle of activity clears state
      step(HALF - 1, 1'b1);
      do_reset();
      step(0, 1'b1);
      chk(decode(trit_out) == 0, "R1", decode(trit_out), 0);

      // Every DC level of the input range, from a clean reset
      for (int d = -HALF; d < HALF; d++) begin
         do_reset();
         for (int k = 0; k < 40; k++) step(d, 1'b1);
      end

      // Pseudo-random walk with random strobe gaps
      do_reset();
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = int'($urandom_range(HALF * 2 - 1, 0)) - HALF;
         step(r, ($urandom_range(3, 0) != 0));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule